// File: doc/BRIEF.md
# Derived Operand Address Generator

This block works out where the second operand of an instruction lives, for a 16-bit processor with a sixteen-entry general register file. The decoder hands it several fields: an addressing-mode code, an index-register field, a base-register select, a displacement and a single/double precision flag. The block reads the register values it needs through two combinational read ports.

One clock later it presents four results:
- the 16-bit effective word address;
- the address of the second word of a double-precision operand;
- the number or numbers of the register that holds the first operand;
- a flag telling whether the operand needs a memory access at all.

A valid strobe marks the cycle in which these results are fresh. All address arithmetic wraps silently at 16 bits. Index field value 0 means "no index" rather than R0. Base-relative addressing draws its base from R12–R15 only. In that mode the first operand is fixed: R2 for single precision, the R0/R1 pair for double precision. Stack addressing takes R15 as the address.

Top module: `dopag_top`

## Requirements
- R1: `valid_o` is high in exactly the cycle after a cycle with `req_i` high. A synchronous active-high `rst` clears `valid_o`, `ea_o`, `ea2_o`, `nomem_o`, `op1_o` and `op1_pair_o` to 0.
- R2: In memory-direct mode (`mode_i` = 2), `ea_o` = `disp_i` + R[`idx_i`] modulo 2^16. Read port B carries `idx_i` as its address.
- R3: An `idx_i` of 0 adds nothing, whatever R0 holds. This holds in both memory-direct and base-relative modes.
- R4: In base-relative mode (`mode_i` = 3), the base register is R(12 + `base_sel_i`), read on port A. `ea_o` = R[base] + zero-extended `disp_i[7:0]` + optional index, modulo 2^16. `disp_i[15:8]` has no effect.
- R5: In base-relative mode, `op1_o`/`op1_pair_o` are 2/2 when `dbl_i` = 0 and 0/1 when `dbl_i` = 1. In this mode `opreg_i` has no effect.
- R6: In stack mode (`mode_i` = 4), port A addresses R15 and `ea_o` = R15. The index and displacement have no effect.
- R7: For a memory operand, `ea2_o` = `ea_o` + 1 modulo 2^16 when `dbl_i` = 1, and `ea2_o` = `ea_o` when `dbl_i` = 0.
- R8: Register-direct (`mode_i` = 0), immediate (1) and the reserved codes 5–7 set `nomem_o` = 1 and give `ea_o` = `ea2_o` = 0. Every memory mode gives `nomem_o` = 0.
- R9: Outside base-relative mode, `op1_o` = `opreg_i`. `op1_pair_o` = `opreg_i` + 1 modulo 16 when `dbl_i` = 1, and `opreg_i` otherwise.
- R10: In a cycle without `req_i`, the registered outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request: decoded fields are present |
| mode_i | input | 3 | Addressing-mode code |
| idx_i | input | 4 | Index register field, 0 = none |
| base_sel_i | input | 2 | Base register select, R12 + value |
| disp_i | input | 16 | Displacement word |
| dbl_i | input | 1 | Double-precision operand |
| opreg_i | input | 4 | First-operand register from the opcode |
| rd_addr_a_o | output | 4 | Read port A address (base / stack) |
| rd_data_a_i | input | 16 | Read port A data |
| rd_addr_b_o | output | 4 | Read port B address (index) |
| rd_data_b_i | input | 16 | Read port B data |
| valid_o | output | 1 | Results valid |
| ea_o | output | 16 | Effective address |
| ea2_o | output | 16 | Second-word address |
| nomem_o | output | 1 | No memory access needed |
| op1_o | output | 4 | First-operand register |
| op1_pair_o | output | 4 | Second register of the first operand |

## Verification
Random requests cover all eight mode codes, the whole index range and random register contents. These separate a wrong mode decode from wrong adder operands. Directed cases place large values in R0 with index 0, which exposes an index path that reads R0. They also set high displacement bits in base-relative mode, which exposes a missing zero-extension. Sums near 0xFFFF expose carries that fail to wrap into `ea_o` and `ea2_o`. Idle cycles between requests show whether the outputs hold, and double requests in base-relative mode separate the fixed first operand from `opreg_i`.

// File: rtl/dopag_pkg.sv
package dopag_pkg;
    localparam int ADDR_W = 16;
    localparam int NREGS  = 16;
    localparam int RSEL_W = $clog2(NREGS);
    localparam int BSEL_W = 2;
    localparam int BDISP_W = 8;
    localparam logic [RSEL_W-1:0] BASE_FIRST = RSEL_W'(NREGS - (1 << BSEL_W));
    localparam logic [RSEL_W-1:0] STACK_REG  = RSEL_W'(NREGS - 1);
    localparam logic [RSEL_W-1:0] BR_SGL_OP  = RSEL_W'(2);
    localparam logic [RSEL_W-1:0] BR_DBL_OP  = RSEL_W'(0);

    typedef enum logic [2:0] {
        MODE_REG   = 3'd0,
        MODE_IMM   = 3'd1,
        MODE_MEM   = 3'd2,
        MODE_BASE  = 3'd3,
        MODE_STACK = 3'd4
    } dop_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] ea;
        logic [ADDR_W-1:0] ea2;
        logic              nomem;
        logic [RSEL_W-1:0] op1;
        logic [RSEL_W-1:0] op1_pair;
    } dop_res_t;

    function automatic logic mode_has_mem(input logic [2:0] m);
        return (m == MODE_MEM) || (m == MODE_BASE) || (m == MODE_STACK);
    endfunction
endpackage

// File: rtl/dopag_srcsel.sv
module dopag_srcsel
    import dopag_pkg::*;
(
    input  logic [2:0]        mode,
    input  logic [RSEL_W-1:0] idx,
    input  logic [BSEL_W-1:0] base_sel,
    input  logic [ADDR_W-1:0] disp,
    input  logic [ADDR_W-1:0] port_a_data,
    input  logic [ADDR_W-1:0] port_b_data,
    output logic [RSEL_W-1:0] port_a_addr,
    output logic [ADDR_W-1:0] base_term,
    output logic [ADDR_W-1:0] disp_term,
    output logic [ADDR_W-1:0] idx_term,
    output logic              nomem
);
    logic use_idx;

    always_comb begin
        port_a_addr = '0;
        base_term   = '0;
        disp_term   = '0;
        use_idx     = 1'b0;
        nomem       = !mode_has_mem(mode);
        case (mode)
            MODE_MEM: begin
                disp_term = disp;
                use_idx   = 1'b1;
            end
            MODE_BASE: begin
                port_a_addr = BASE_FIRST | RSEL_W'(base_sel);
                base_term   = port_a_data;
                disp_term   = ADDR_W'(disp[BDISP_W-1:0]);
                use_idx     = 1'b1;
            end
            MODE_STACK: begin
                port_a_addr = STACK_REG;
                base_term   = port_a_data;
            end
            default: ;
        endcase
        idx_term = (use_idx && idx != '0) ? port_b_data : '0;
    end
endmodule

// File: rtl/dopag_sum.sv
module dopag_sum
    import dopag_pkg::*;
(
    input  logic [ADDR_W-1:0] base_term,
    input  logic [ADDR_W-1:0] disp_term,
    input  logic [ADDR_W-1:0] idx_term,
    input  logic              dbl,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] ea2
);
    always_comb begin
        ea  = base_term + disp_term + idx_term;
        ea2 = dbl ? ea + ADDR_W'(1) : ea;
    end
endmodule

// File: rtl/dopag_top.sv
module dopag_top
    import dopag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_i,
    input  logic [2:0]  mode_i,
    input  logic [3:0]  idx_i,
    input  logic [1:0]  base_sel_i,
    input  logic [15:0] disp_i,
    input  logic        dbl_i,
    input  logic [3:0]  opreg_i,
    output logic [3:0]  rd_addr_a_o,
    input  logic [15:0] rd_data_a_i,
    output logic [3:0]  rd_addr_b_o,
    input  logic [15:0] rd_data_b_i,
    output logic        valid_o,
    output logic [15:0] ea_o,
    output logic [15:0] ea2_o,
    output logic        nomem_o,
    output logic [3:0]  op1_o,
    output logic [3:0]  op1_pair_o
);
    logic [ADDR_W-1:0] base_term, disp_term, idx_term, sum_ea, sum_ea2;
    logic              nomem_c;
    dop_res_t          res_c, res_q;
    logic              valid_q, dbl_q;

    assign rd_addr_b_o = idx_i;

    dopag_srcsel u_srcsel (
        .mode        (mode_i),
        .idx         (idx_i),
        .base_sel    (base_sel_i),
        .disp        (disp_i),
        .port_a_data (rd_data_a_i),
        .port_b_data (rd_data_b_i),
        .port_a_addr (rd_addr_a_o),
        .base_term   (base_term),
        .disp_term   (disp_term),
        .idx_term    (idx_term),
        .nomem       (nomem_c)
    );

    dopag_sum u_sum (
        .base_term (base_term),
        .disp_term (disp_term),
        .idx_term  (idx_term),
        .dbl       (dbl_i),
        .ea        (sum_ea),
        .ea2       (sum_ea2)
    );

    always_comb begin
        res_c.nomem = nomem_c;
        res_c.ea    = nomem_c ? '0 : sum_ea;
        res_c.ea2   = nomem_c ? '0 : sum_ea2;
        if (mode_i == MODE_BASE) begin
            res_c.op1      = dbl_i ? BR_DBL_OP : BR_SGL_OP;
            res_c.op1_pair = dbl_i ? BR_DBL_OP + RSEL_W'(1) : BR_SGL_OP;
        end else begin
            res_c.op1      = opreg_i;
            res_c.op1_pair = dbl_i ? opreg_i + RSEL_W'(1) : opreg_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            dbl_q   <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= req_i;
            if (req_i) begin
                res_q <= res_c;
                dbl_q <= dbl_i;
            end
        end
    end

    assign valid_o    = valid_q;
    assign ea_o       = res_q.ea;
    assign ea2_o      = res_q.ea2;
    assign nomem_o    = res_q.nomem;
    assign op1_o      = res_q.op1;
    assign op1_pair_o = res_q.op1_pair;

    // R1: the strobe follows a request by one cycle
    p_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        req_i |=> valid_o);
    // R8: no memory access means a zero address
    p_nomem_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (valid_o && nomem_o) |-> (ea_o == '0 && ea2_o == '0));
    // R7: the second word sits right after the first
    p_second_word_r7: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !nomem_o && dbl_q) |-> (ea2_o == ADDR_W'(ea_o + 1'b1)));
    // R10: the outputs hold without a request
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> ($stable(ea_o) && $stable(op1_o) && $stable(nomem_o)));
    // R5: base-relative first operand is R2 or R0
    p_base_op1_r5: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode_i == MODE_BASE) |=> (op1_o == BR_SGL_OP || op1_o == BR_DBL_OP));
    // R6: stack mode reads R15
    p_stack_port_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_STACK) |-> (rd_addr_a_o == STACK_REG));
endmodule

// File: tb/dopag_top_tb_top.sv
module dopag_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [3:0]  idx_i = '0;
    logic [1:0]  base_sel_i = '0;
    logic [15:0] disp_i = '0;
    logic        dbl_i = 1'b0;
    logic [3:0]  opreg_i = '0;
    logic [3:0]  rd_addr_a_o, rd_addr_b_o;
    logic [15:0] rd_data_a_i, rd_data_b_i;
    logic        valid_o, nomem_o;
    logic [15:0] ea_o, ea2_o;
    logic [3:0]  op1_o, op1_pair_o;
    logic [15:0] regs [16];
    int          total = 0;
    int          bad = 0;

    always #2 clk = ~clk;

    assign rd_data_a_i = regs[rd_addr_a_o];
    assign rd_data_b_i = regs[rd_addr_b_o];

    dopag_top dut_i (
        .clk(clk), .rst(rst), .req_i(req_i), .mode_i(mode_i), .idx_i(idx_i),
        .base_sel_i(base_sel_i), .disp_i(disp_i), .dbl_i(dbl_i), .opreg_i(opreg_i),
        .rd_addr_a_o(rd_addr_a_o), .rd_data_a_i(rd_data_a_i),
        .rd_addr_b_o(rd_addr_b_o), .rd_data_b_i(rd_data_b_i),
        .valid_o(valid_o), .ea_o(ea_o), .ea2_o(ea2_o), .nomem_o(nomem_o),
        .op1_o(op1_o), .op1_pair_o(op1_pair_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_ea(input logic [2:0] m, input logic [3:0] ix,
                                           input logic [1:0] bs, input logic [15:0] d);
        logic [15:0] ixv;
        ixv = (ix == 0) ? 16'h0 : regs[ix];
        case (m)
            3'd2: return d + ixv;
            3'd3: return regs[12 + bs] + {8'h00, d[7:0]} + ixv;
            3'd4: return regs[15];
            default: return 16'h0;
        endcase
    endfunction

    task automatic run_one(input logic [2:0] m, input logic [3:0] ix, input logic [1:0] bs,
                           input logic [15:0] d, input logic db, input logic [3:0] opr);
        logic [15:0] e, e2;
        logic        nm;
        logic [3:0]  o1, o2;
        @(negedge clk);
        mode_i = m; idx_i = ix; base_sel_i = bs; disp_i = d; dbl_i = db; opreg_i = opr;
        req_i = 1'b1;
        nm = !(m == 3'd2 || m == 3'd3 || m == 3'd4);
        e  = exp_ea(m, ix, bs, d);
        e2 = (!nm && db) ? e + 16'd1 : e;
        if (m == 3'd3) begin o1 = db ? 4'd0 : 4'd2; o2 = db ? 4'd1 : 4'd2; end
        else begin o1 = opr; o2 = db ? opr + 4'd1 : opr; end
        #1;
        if (m == 3'd4) check("R6 port A addr", {12'h0, rd_addr_a_o}, 16'd15);
        if (m == 3'd3) check("R4 port A addr", {12'h0, rd_addr_a_o}, {12'h0, 4'd12 + {2'b00, bs}});
        @(negedge clk);
        req_i = 1'b0;
        check("R1 valid", {15'h0, valid_o}, 16'd1);
        check(m == 3'd2 ? "R2 ea" : m == 3'd3 ? "R4 ea" : m == 3'd4 ? "R6 ea" : "R8 ea", ea_o, e);
        check("R7 ea2", ea2_o, e2);
        check("R8 nomem", {15'h0, nomem_o}, {15'h0, nm});
        check(m == 3'd3 ? "R5 op1" : "R9 op1", {12'h0, op1_o}, {12'h0, o1});
        check(m == 3'd3 ? "R5 pair" : "R9 pair", {12'h0, op1_pair_o}, {12'h0, o2});
        // R10: an idle cycle with other inputs changing
        mode_i = 3'd2; disp_i = ~d; idx_i = 4'd0;
        @(negedge clk);
        check("R1 valid low", {15'h0, valid_o}, 16'd0);
        check("R10 hold ea", ea_o, e);
        check("R10 hold op1", {12'h0, op1_o}, {12'h0, o1});
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1750));
        for (int i = 0; i < 16; i++) regs[i] = 16'h1000 * i[15:0] + 16'h0011;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset valid", {15'h0, valid_o}, 16'd0);
        check("R1 reset ea", ea_o, 16'h0);
        check("R1 reset op1", {12'h0, op1_o}, 16'h0);
        rst = 1'b0;
        // R3: R0 loaded but index 0 adds nothing
        regs[0] = 16'hBEEF;
        run_one(3'd2, 4'd0, 2'd0, 16'h1234, 1'b0, 4'd5);
        run_one(3'd3, 4'd0, 2'd1, 16'h0040, 1'b1, 4'd9);
        // R4: high displacement bits ignored
        run_one(3'd3, 4'd3, 2'd3, 16'hFF80, 1'b0, 4'd7);
        // R7: wrap at 0xFFFF
        run_one(3'd2, 4'd0, 2'd0, 16'hFFFF, 1'b1, 4'd15);
        regs[15] = 16'hFFFF;
        run_one(3'd4, 4'd6, 2'd2, 16'h5555, 1'b1, 4'd3);
        // R8: register, immediate, reserved
        run_one(3'd0, 4'd4, 2'd0, 16'h7777, 1'b1, 4'd4);
        run_one(3'd1, 4'd1, 2'd0, 16'h0001, 1'b0, 4'd1);
        run_one(3'd6, 4'd2, 2'd1, 16'h0101, 1'b0, 4'd8);
        // R2/R4/R6/R9 random
        for (int k = 0; k < 400; k++) begin
            for (int r = 0; r < 16; r++) regs[r] = 16'($urandom);
            run_one(3'($urandom), 4'($urandom), 2'($urandom), 16'($urandom),
                    1'($urandom), 4'($urandom));
        end
        // R1: reset clears results
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears ea", ea_o, 16'h0);
        check("R1 reset clears valid", {15'h0, valid_o}, 16'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule